// File: doc/BRIEF.md
# Multi-Format Stereo Audio Receiver

This block turns a serial stereo audio stream into parallel sample pairs. It runs entirely on the incoming bit clock as a slave: the data line and the word-select (or frame-pulse) line are both sampled on every rising bit-clock edge. A static format input selects how sample boundaries are found. The choices are a word-select format where the MSB trails the transition by one edge, a right-justified format where the LSB lands just before the transition, and two frame-pulse formats that differ by one edge of MSB delay.

The word length is chosen from four static settings. Each received word is returned MSB-aligned in an output of `OUT_W` bits, with zeros below it. When the right-channel word of a frame is complete, the block presents both channel words and raises a one-cycle valid strobe. Bit-clock cycles that carry no sample bits are ignored. In the frame-pulse formats, a pulse whose preceding low phase is too short raises a sticky error flag, which stays set until it is cleared.

An asynchronous active-low reset enters the block directly. Its release is synchronised to the bit clock inside the block.

Top module: `pcm_stereo_rx`

## Requirements
- R1: Bits arrive MSB first. The word-length code sets the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Each word is output MSB-aligned with zero padding below it.
- R2: Format code 0 (word-select, delayed). The MSB is the bit sampled on the edge after the edge at which a change in word-select is first seen. Word-select low selects the left channel and high selects the right channel.
- R3: Format code 1 (right-justified). The LSB is the bit sampled on the last edge before the edge at which a word-select change is seen. The word is taken at that change and belongs to the channel given by the old word-select level (low is left).
- R4: Format codes 2 and 3 (frame pulse). With code 3, the left MSB is sampled on the edge that first sees the pulse high. With code 2, it is sampled one edge later. The right word follows the left LSB with no gap.
- R5: One edge after the right word of a frame is complete, `valid_o` is high for exactly one cycle, with both words presented. Between strobes, both outputs keep their values.
- R6: Bit-clock cycles that fall outside a word's bits, filled with arbitrary data, do not change the captured words.
- R7: In the frame-pulse formats, a pulse rising edge that was preceded by only one low sample sets `pulse_err_o`. The flag stays set until `err_clr_i` is applied. It is never set in formats 0 and 1.
- R8: After reset, both data outputs are zero, and `valid_o` and `pulse_err_o` are low.
- R9: A new boundary that arrives before a word is complete abandons that word, and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing format: 0 delayed word-select, 1 right-justified, 2 pulse with late MSB, 3 pulse with early MSB |
| wlen_i | input | 2 | Word-length code (16/20/24/32 bits) |
| ws_i | input | 1 | Word-select level or frame pulse |
| sd_i | input | 1 | Serial data |
| err_clr_i | input | 1 | Clears the frame-pulse error flag |
| left_o | output | OUT_W | Left-channel word, MSB-aligned |
| right_o | output | OUT_W | Right-channel word, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe when a frame pair is ready |
| pulse_err_o | output | 1 | Sticky frame-pulse low-time error |

## Verification
The bench uses the default `OUT_W` of 32 and a two-stage reset synchroniser. This lets every word-length code be tried, including the full 32-bit word, where the last bit of one channel lands on the boundary edge of the next. Slot sizes range from tight (no spare cycles) to loose (noisy spare cycles). Pulse widths range from one edge up to a pulse that leaves a single low sample. The bench also tries a slot that is too short to complete a word, and a word-select that toggles on every edge.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_WS_DELAYED = 2'd0,
    FMT_RIGHT_JUST = 2'd1,
    FMT_PULSE_LATE = 2'd2,
    FMT_PULSE_EARLY = 2'd3
  } fmt_e;

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_frame_sync.sv
module pcm_rx_frame_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_i,
  input  logic pulse_mode_i,
  input  logic err_clr_i,
  output logic ws_prev_o,
  output logic ws_edge_o,
  output logic ws_rise_o,
  output logic pulse_err_o
);

  logic ws_q;
  logic ws_q2;
  logic err_q;
  logic err_d;
  logic short_low;

  always_comb begin
    ws_edge_o = ws_i ^ ws_q;
    ws_rise_o = ws_i & ~ws_q;
    ws_prev_o = ws_q;
    // rise seen with only one low sample before it
    short_low = ws_rise_o & ws_q2;
    err_d = err_q;
    if (err_clr_i) err_d = 1'b0;
    if (pulse_mode_i && short_low) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q  <= 1'b0;
      ws_q2 <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ws_q  <= ws_i;
      ws_q2 <= ws_q;
      err_q <= err_d;
    end
  end

  assign pulse_err_o = err_q;

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_err_o && !err_clr_i) |=> pulse_err_o);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !pulse_mode_i) |=> !pulse_err_o);

  p_err_pulse_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode_i && !pulse_err_o) |=> !pulse_err_o);

endmodule

// File: rtl/pcm_rx_slot_counter.sv
module pcm_rx_slot_counter
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             ws_i,
  input  logic             ws_prev_i,
  input  logic             ws_edge_i,
  input  logic             ws_rise_i,
  output logic             done_o,
  output logic             chan_o,
  output logic             rj_win_o
);

  logic             arm_q, arm_d;
  logic             arm_ch_q, arm_ch_d;
  logic             busy_q, busy_d;
  logic             ch_q, ch_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             is_ws, is_rj, is_pulse;
  logic             start_now, start_ch, last_bit;

  always_comb begin
    is_ws    = (fmt_i == FMT_WS_DELAYED);
    is_rj    = (fmt_i == FMT_RIGHT_JUST);
    is_pulse = (fmt_i == FMT_PULSE_LATE) || (fmt_i == FMT_PULSE_EARLY);

    // delayed formats: first bit lands one edge after the boundary
    arm_d    = (is_ws && ws_edge_i) || ((fmt_i == FMT_PULSE_LATE) && ws_rise_i);
    arm_ch_d = is_ws & ws_i;

    start_now = arm_q || ((fmt_i == FMT_PULSE_EARLY) && ws_rise_i);
    start_ch  = arm_q ? arm_ch_q : 1'b0;

    cnt_inc  = cnt_q + 1'b1;
    last_bit = busy_q && (cnt_inc == nbits_i);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    ch_d   = ch_q;
    if (is_rj) begin
      busy_d = 1'b0;
    end else if (start_now) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      ch_d   = start_ch;
    end else if (busy_q) begin
      if (last_bit) begin
        if (is_pulse && !ch_q) begin
          cnt_d = '0;
          ch_d  = 1'b1;
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_inc;
      end
    end

    done_o   = is_rj ? ws_edge_i : last_bit;
    chan_o   = is_rj ? ws_prev_i : ch_q;
    rj_win_o = is_rj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= 1'b0;
      arm_ch_q <= 1'b0;
      busy_q   <= 1'b0;
      ch_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      arm_q    <= arm_d;
      arm_ch_q <= arm_ch_d;
      busy_q   <= busy_d;
      ch_q     <= ch_d;
      cnt_q    <= cnt_d;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < nbits_i));

  p_pulse_left_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && start_now) |=> (busy_q && !ch_q));

  p_rj_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_rj |=> !busy_q);

endmodule

// File: rtl/pcm_rx_word_assembler.sv
module pcm_rx_word_assembler #(
  parameter int OUT_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             done_i,
  input  logic             chan_i,
  input  logic             rj_win_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  logic [OUT_W-1:0] sh_q, sh_d;
  logic [OUT_W-1:0] hold_q, hold_d;
  logic [OUT_W-1:0] left_q, left_d;
  logic [OUT_W-1:0] right_q, right_d;
  logic             valid_q, valid_d;
  logic [OUT_W-1:0] win;
  logic [OUT_W-1:0] aligned;
  logic [CNT_W-1:0] pad;

  always_comb begin
    sh_d = {sh_q[OUT_W-2:0], sd_i};
    // right-justified takes the word before the current bit
    win     = rj_win_i ? sh_q : sh_d;
    pad     = CNT_W'(OUT_W) - nbits_i;
    aligned = win << pad;

    hold_d  = hold_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (done_i) begin
      if (!chan_i) begin
        hold_d = aligned;
      end else begin
        left_d  = hold_q;
        right_d = aligned;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      hold_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      hold_q  <= hold_d;
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((right_q << nbits_i) == '0));

endmodule

// File: rtl/pcm_stereo_rx.sv
module pcm_stereo_rx
  import pcm_rx_pkg::*;
#(
  parameter int OUT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             bclk_i,
  input  logic             rst_n_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wlen_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic             err_clr_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             pulse_err_o
);

  localparam int CNT_W = $clog2(OUT_W + 1);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n;
  fmt_e                   fmt;
  logic [CNT_W-1:0]       nbits;
  logic                   ws_prev, ws_edge, ws_rise;
  logic                   done, chan, rj_win;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
    if (s == 0) begin : g_first
      always_ff @(posedge bclk_i or negedge rst_n_i) begin
        if (!rst_n_i) rst_pipe[s] <= 1'b0;
        else          rst_pipe[s] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge bclk_i or negedge rst_n_i) begin
        if (!rst_n_i) rst_pipe[s] <= 1'b0;
        else          rst_pipe[s] <= rst_pipe[s-1];
      end
    end
  end

  assign rst_n = rst_pipe[SYNC_STAGES-1];
  assign fmt   = fmt_e'(fmt_i);
  assign nbits = CNT_W'(word_bits(wlen_i));

  pcm_rx_frame_sync i_frame_sync (
    .clk          (bclk_i),
    .rst_n        (rst_n),
    .ws_i         (ws_i),
    .pulse_mode_i (fmt_i[1]),
    .err_clr_i    (err_clr_i),
    .ws_prev_o    (ws_prev),
    .ws_edge_o    (ws_edge),
    .ws_rise_o    (ws_rise),
    .pulse_err_o  (pulse_err_o)
  );

  pcm_rx_slot_counter #(.CNT_W(CNT_W)) i_slot_counter (
    .clk       (bclk_i),
    .rst_n     (rst_n),
    .fmt_i     (fmt),
    .nbits_i   (nbits),
    .ws_i      (ws_i),
    .ws_prev_i (ws_prev),
    .ws_edge_i (ws_edge),
    .ws_rise_i (ws_rise),
    .done_o    (done),
    .chan_o    (chan),
    .rj_win_o  (rj_win)
  );

  pcm_rx_word_assembler #(.OUT_W(OUT_W), .CNT_W(CNT_W)) i_word_assembler (
    .clk      (bclk_i),
    .rst_n    (rst_n),
    .sd_i     (sd_i),
    .nbits_i  (nbits),
    .done_i   (done),
    .chan_i   (chan),
    .rj_win_i (rj_win),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  p_reset_quiet_r8: assert property (@(posedge bclk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (!valid_o && !pulse_err_o));

endmodule

// File: tb/test_pcm_stereo_rx.sv
module test_pcm_stereo_rx;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OUT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ws = 1'b0;
  logic             sd = 1'b0;
  logic             clr = 1'b0;
  logic [1:0]       fmt = 2'd0;
  logic [1:0]       wlen = 2'd0;
  logic [OUT_W-1:0] left_o, right_o;
  logic             valid_o, err_o;

  int tests = 0;
  int fails = 0;
  int edge_cnt = 0;
  logic [31:0] lw [4];
  logic [31:0] rw [4];
  int          exp_stamp [4];
  logic [31:0] cap_l [64];
  logic [31:0] cap_r [64];
  int          cap_s [64];
  int          cap_n = 0;

  pcm_stereo_rx #(.OUT_W(OUT_W), .SYNC_STAGES(2)) i_pcm_stereo_rx (
    .bclk_i      (clk),
    .rst_n_i     (rst_n),
    .fmt_i       (fmt),
    .wlen_i      (wlen),
    .ws_i        (ws),
    .sd_i        (sd),
    .err_clr_i   (clr),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .pulse_err_o (err_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  always @(negedge clk) begin
    if (valid_o) begin
      if (cap_n < 64) begin
        cap_l[cap_n] = left_o;
        cap_r[cap_n] = right_o;
        cap_s[cap_n] = edge_cnt;
      end
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int wl(input int code);
    case (code)
      0:       return 16;
      1:       return 20;
      2:       return 24;
      default: return 32;
    endcase
  endfunction

  task automatic drive(input logic w, input logic d);
    @(negedge clk);
    ws = w;
    sd = d;
  endtask

  task automatic do_reset(input int f, input int wc, input logic ws0);
    rst_n = 1'b0;
    fmt   = f[1:0];
    wlen  = wc[1:0];
    ws    = ws0;
    sd    = 1'b0;
    clr   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // S is the channel slot for formats 0/1, the frame length for 2/3
  task automatic run_stream(input int f, input int wc, input int S, input int W,
                            input int F, input int n_exp, input string req);
    int N, per, base, got;
    logic w, d, wlast;
    N   = wl(wc);
    per = (f >= 2) ? S : 2 * S;
    do_reset(f, wc, (f == 0));
    base  = cap_n;
    wlast = (f == 0);
    repeat (4) drive(wlast, 1'b0);
    for (int p = 0; p <= per * F + 1; p++) begin
      int q, r, fr, j, stamp_f;
      q = p % per;
      d = (p % 3 == 0) ^ p[2];
      stamp_f = -1;
      if (f == 0) begin
        w = (q >= S);
        if (p >= 1) begin
          r  = (p - 1) % per;
          fr = (p - 1) / per;
          if (fr < F) begin
            if (r < N) d = lw[fr][N-1-r];
            else if (r >= S && r < S + N) begin
              j = r - S;
              d = rw[fr][N-1-j];
              if (j == N - 1) stamp_f = fr;
            end
          end
        end
      end else if (f == 1) begin
        w  = (q >= S);
        fr = p / per;
        if (fr < F) begin
          if (q >= S - N && q < S) d = lw[fr][N-1-(q-(S-N))];
          if (q >= per - N) d = rw[fr][N-1-(q-(per-N))];
        end
      end else begin
        int off;
        off = (f == 2) ? 1 : 0;
        w   = (q < W);
        if (p >= off) begin
          r  = (p - off) % per;
          fr = (p - off) / per;
          if (fr < F) begin
            if (r < N) d = lw[fr][N-1-r];
            else if (r < 2 * N) begin
              d = rw[fr][N-1-(r-N)];
              if (r == 2 * N - 1) stamp_f = fr;
            end
          end
        end
      end
      drive(w, d);
      wlast = w;
      if (stamp_f >= 0) exp_stamp[stamp_f] = edge_cnt + 1;
      if (f == 1 && q == 0 && p > 0 && (p / per) <= F) exp_stamp[p/per-1] = edge_cnt + 1;
    end
    repeat (6) drive(wlast, 1'b0);
    got = cap_n - base;
    chk(got == n_exp, req, "frame count", got, n_exp);
    for (int k = 0; k < n_exp && k < got; k++) begin
      chk(cap_l[base+k] == (lw[k] << (32 - N)), req, "left word", cap_l[base+k], lw[k] << (32 - N));
      chk(cap_r[base+k] == (rw[k] << (32 - N)), req, "right word", cap_r[base+k], rw[k] << (32 - N));
      chk(cap_s[base+k] == exp_stamp[k], req, "strobe edge", cap_s[base+k], exp_stamp[k]);
    end
    if (n_exp > 0 && got == n_exp) begin
      // R5: outputs hold after the last strobe
      chk(left_o == (lw[n_exp-1] << (32 - N)), "R5", "held left", left_o, lw[n_exp-1] << (32 - N));
      chk(right_o == (rw[n_exp-1] << (32 - N)), "R5", "held right", right_o, rw[n_exp-1] << (32 - N));
    end
  endtask

  task automatic t_reset_r8();
    do_reset(0, 0, 1'b0);
    chk(left_o == '0, "R8", "left after reset", left_o, 0);
    chk(right_o == '0, "R8", "right after reset", right_o, 0);
    chk(valid_o == 1'b0, "R8", "valid after reset", valid_o, 0);
    chk(err_o == 1'b0, "R8", "error after reset", err_o, 0);
  endtask

  task automatic t_ws_delayed_r2();
    lw[0] = 32'h00A5C3F1; rw[0] = 32'h005A3C0E;
    lw[1] = 32'h00800001; rw[1] = 32'h00FFFFFE;
    lw[2] = 32'h00123456; rw[2] = 32'h00FEDCBA;
    run_stream(0, 2, 32, 0, 3, 3, "R2/R6 24b");
    lw[0] = 32'h80000001; rw[0] = 32'hDEADBEEF;
    lw[1] = 32'h7FFFFFFE; rw[1] = 32'h01234567;
    run_stream(0, 3, 32, 0, 2, 2, "R2/R1 32b tight");
    chk(err_o == 1'b0, "R7", "no error in word-select format", err_o, 0);
  endtask

  task automatic t_right_just_r3();
    lw[0] = 32'h000ABCDE; rw[0] = 32'h00012345;
    lw[1] = 32'h00080001; rw[1] = 32'h000FFFFF;
    lw[2] = 32'h00055555; rw[2] = 32'h000AAAAA;
    run_stream(1, 1, 24, 0, 3, 3, "R3/R6 20b");
    lw[0] = 32'h0000F00D; rw[0] = 32'h00008001;
    lw[1] = 32'h00001234; rw[1] = 32'h0000FFFF;
    run_stream(1, 0, 16, 0, 2, 2, "R3/R1 16b tight");
  endtask

  task automatic t_pulse_r4();
    lw[0] = 32'h0000C0DE; rw[0] = 32'h0000BEEF;
    lw[1] = 32'h00008000; rw[1] = 32'h00000001;
    lw[2] = 32'h00007E57; rw[2] = 32'h0000A11A;
    run_stream(2, 0, 40, 1, 3, 3, "R4 late 16b");
    lw[0] = 32'hCAFEF00D; rw[0] = 32'h13579BDF;
    lw[1] = 32'h00000001; rw[1] = 32'h80000000;
    run_stream(3, 3, 64, 1, 2, 2, "R4 early 32b back-to-back");
    lw[0] = 32'h00ABCDEF; rw[0] = 32'h00FEDCBA;
    lw[1] = 32'h00400002; rw[1] = 32'h00200004;
    run_stream(3, 2, 60, 20, 2, 2, "R4/R6 early 24b wide pulse");
    chk(err_o == 1'b0, "R7", "wide pulse with long low gap", err_o, 0);
  endtask

  task automatic t_pulse_err_r7();
    lw[0] = 32'h00001111; rw[0] = 32'h00002222;
    lw[1] = 32'h00003333; rw[1] = 32'h00004444;
    run_stream(2, 0, 40, 39, 2, 2, "R7 data with short gap");
    chk(err_o == 1'b1, "R7", "error set by one-sample low", err_o, 1);
    drive(ws, 1'b0);
    chk(err_o == 1'b1, "R7", "error sticky", err_o, 1);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(err_o == 1'b0, "R7", "error cleared", err_o, 0);
    lw[0] = 32'h0; rw[0] = 32'h0;
    lw[1] = 32'h0; rw[1] = 32'h0;
    lw[2] = 32'h0; rw[2] = 32'h0;
    run_stream(0, 0, 1, 0, 3, 0, "R7/R9 toggling word-select");
    chk(err_o == 1'b0, "R7", "no error outside pulse formats", err_o, 0);
  endtask

  task automatic t_abandon_r9();
    lw[0] = 32'hFFFF; rw[0] = 32'hFFFF;
    lw[1] = 32'hFFFF; rw[1] = 32'hFFFF;
    lw[2] = 32'hFFFF; rw[2] = 32'hFFFF;
    run_stream(0, 0, 12, 0, 3, 0, "R9 short slot");
    chk(valid_o == 1'b0 && left_o == '0, "R9", "outputs untouched", left_o, 0);
  endtask

  initial begin
    t_reset_r8();
    t_ws_delayed_r2();
    t_right_just_r3();
    t_pulse_r4();
    t_pulse_err_r7();
    t_abandon_r9();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(150000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule